// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Window

This block is the software-visible register window of a two-channel IDE bus-master DMA engine. It occupies a 16-byte I/O range. Each channel gets 8 bytes: a command/status dword and a descriptor-table address dword. The window holds the start and direction controls, the active and interrupt status, two software-owned drive-capability flags and the descriptor-table base pointer. The start, direction and interrupt-pending state of each channel is driven onto plain pins so that the data mover and the interrupt logic can use it.

Accesses arrive on a request stream with valid/ready. `req_ready` is always high, so a request is accepted in every cycle in which `req_valid` is high and no back-pressure is ever applied. Each accepted read produces exactly one response beat, one cycle later. The response has no ready, so the consumer must take it in that cycle. A write produces no response.

The command/status dword accepts only single-byte accesses. A wider read of that dword returns all ones for its width, and a wider write to it is discarded. The per-channel interrupt input pulses set a sticky interrupt bit, which software clears by writing 1 to it.

Top module: `bmdma_regwin`

## Requirements
- R1: `req_ready` is always 1. A read accepted at a clock edge raises `rsp_valid` for exactly the following cycle, with `rsp_rdata`. An accepted write raises no response.
- R2: Decode works as follows. `req_addr[3]` selects the channel. `req_addr[2]`=0 selects the command/status dword and 1 selects the address dword. `req_addr[1:0]` is the byte lane. `req_size` is 0 for byte, 1 for 16-bit, and 2 or 3 for 32-bit. Byte and 16-bit data sit in the low bits of `req_wdata`/`rsp_rdata`, and the upper bits of a byte read are 0.
- R3: The command byte is lane 0. Bit 0 is start and bit 3 is direction (1 = toward memory). Its other bits read 0. `dma_start` and `dma_to_mem` show bits 0 and 3 of the command byte, one cycle after the write.
- R4: Status bit 0 (active) is read-only. Every command-byte write loads it with bit 0 of the written value, so writing start=0 clears it.
- R5: Status bit 2 (interrupt) is set by a high `irq_in[n]` at a clock edge. Writing 1 to status bit 2 clears it, and writing 0 leaves it unchanged. If a set and a clear occur in the same cycle, the set wins. `irq_pending[n]` shows the bit.
- R6: The status byte is lane 2. Bits 5 and 6 are plain read/write. Bits 1, 3, 4 and 7 read 0.
- R7: Byte reads of lanes 1 and 3 of the command/status dword return 0xFF. Byte writes to those lanes change nothing.
- R8: A 16-bit read of the command/status dword returns 0x0000FFFF and a 32-bit read returns 0xFFFFFFFF. A non-byte write to it changes nothing.
- R9: The address dword is 32 bits. A 32-bit access uses all four lanes and ignores `req_addr[1:0]`. A byte access covers lane L. A 16-bit access covers lanes L and L+1, clipped at lane 3. A write updates only the covered lanes. A read returns the covered lanes shifted down to bit 0. Bits 1:0 of the stored value always read 0.
- R10: While `rst_n` is low, all command, status and address state is cleared, and `rsp_valid` and the three output vectors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address within the window |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| req_wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| irq_in | input | 2 | Per-channel interrupt set pulse |
| dma_start | output | 2 | Per-channel start control |
| dma_to_mem | output | 2 | Per-channel direction control |
| irq_pending | output | 2 | Per-channel interrupt status |

## Verification
The bench targets a clear and an interrupt pulse arriving in the same cycle. A design that let the clear win would lose an interrupt. It issues 16- and 32-bit accesses to the command/status dword; a design that decoded them as bytes would return live register data on a read, or would start a channel on a write. It reads the filler lanes and performs partial accesses to the address dword at every lane, including a 16-bit access at lane 3, which exposes lane-shift or clipping errors and any leak of the two low pointer bits. It also drops start while active is set, to catch an active bit that fails to follow the start bit.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam logic [1:0] LANE_CMD = 2'd0;
  localparam logic [1:0] LANE_STS = 2'd2;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/bmw_chan.sv
module bmw_chan
  import bmw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             sts_we,
  input  logic [7:0]       wbyte,
  input  logic [LANES-1:0] adr_be,
  input  logic [DW-1:0]    adr_wd,
  input  logic             irq_set,
  output logic [7:0]       cmd_q,
  output logic [7:0]       sts_q,
  output logic [DW-1:0]    adr_q
);
  logic       start_r, dir_r, act_r, irq_r;
  logic [1:0] cap_r;
  logic [DW-1:0] adr_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_r <= 1'b0;
      dir_r   <= 1'b0;
      act_r   <= 1'b0;
    end else if (cmd_we) begin
      start_r <= wbyte[0];
      dir_r   <= wbyte[3];
      act_r   <= wbyte[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_r <= 1'b0;
      cap_r <= 2'b00;
    end else begin
      if (irq_set)
        irq_r <= 1'b1;
      else if (sts_we && wbyte[2])
        irq_r <= 1'b0;
      if (sts_we)
        cap_r <= wbyte[6:5];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        adr_r[8*k +: 8] <= 8'h00;
      else if (adr_be[k])
        adr_r[8*k +: 8] <= adr_wd[8*k +: 8];
    end
  end

  assign cmd_q = {4'b0000, dir_r, 2'b00, start_r};
  assign sts_q = {1'b0, cap_r, 2'b00, irq_r, 1'b0, act_r};
  assign adr_q = {adr_r[DW-1:2], 2'b00};
endmodule

// File: rtl/bmw_rdfmt.sv
module bmw_rdfmt
  import bmw_pkg::*;
(
  input  logic          is_adr,
  input  logic [1:0]    lane,
  input  logic [1:0]    size,
  input  logic [7:0]    cmd,
  input  logic [7:0]    sts,
  input  logic [DW-1:0] adr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] shifted;

  always_comb begin
    shifted = adr >> (8 * lane);
    rdata   = '0;
    if (!is_adr) begin
      unique case (acc_size_e'(size))
        SZ_BYTE: begin
          if (lane == LANE_CMD)      rdata[7:0] = cmd;
          else if (lane == LANE_STS) rdata[7:0] = sts;
          else                       rdata[7:0] = FILL_BYTE;
        end
        SZ_HALF: rdata[15:0] = '1;
        default: rdata = '1;
      endcase
    end else begin
      unique case (acc_size_e'(size))
        SZ_BYTE: rdata[7:0]  = shifted[7:0];
        SZ_HALF: rdata[15:0] = shifted[15:0];
        default: rdata = adr;
      endcase
    end
  end
endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmw_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(NCH)+2:0]   req_addr,
  input  logic [1:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  input  logic [NCH-1:0]           irq_in,
  output logic [NCH-1:0]           dma_start,
  output logic [NCH-1:0]           dma_to_mem,
  output logic [NCH-1:0]           irq_pending
);
  localparam int CW = $clog2(NCH);
  localparam int AW = CW + 3;

  logic [CW-1:0]    ch_sel;
  logic             is_adr, wr_acc, is_byte;
  logic [1:0]       lane;
  logic [LANES-1:0] be;
  logic [DW-1:0]    wd_sh;
  logic [NCH-1:0][7:0]    cmd_v, sts_v;
  logic [NCH-1:0][DW-1:0] adr_v;
  logic [DW-1:0]    rd_fmt;

  assign req_ready = 1'b1;
  assign ch_sel    = req_addr[AW-1:3];
  assign is_adr    = req_addr[2];
  assign lane      = req_addr[1:0];
  assign wr_acc    = req_valid && req_write;
  assign is_byte   = (acc_size_e'(req_size) == SZ_BYTE);

  always_comb begin
    unique case (acc_size_e'(req_size))
      SZ_BYTE: begin be = 4'b0001 << lane; wd_sh = req_wdata << (8 * lane); end
      SZ_HALF: begin be = 4'b0011 << lane; wd_sh = req_wdata << (8 * lane); end
      default: begin be = 4'b1111;         wd_sh = req_wdata;               end
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_acc && (ch_sel == CW'(i));

    bmw_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_we  (hit && !is_adr && is_byte && lane == LANE_CMD),
      .sts_we  (hit && !is_adr && is_byte && lane == LANE_STS),
      .wbyte   (req_wdata[7:0]),
      .adr_be  ((hit && is_adr) ? be : 4'b0000),
      .adr_wd  (wd_sh),
      .irq_set (irq_in[i]),
      .cmd_q   (cmd_v[i]),
      .sts_q   (sts_v[i]),
      .adr_q   (adr_v[i])
    );

    assign dma_start[i]   = cmd_v[i][0];
    assign dma_to_mem[i]  = cmd_v[i][3];
    assign irq_pending[i] = sts_v[i][2];
  end

  bmw_rdfmt u_fmt (
    .is_adr (is_adr),
    .lane   (lane),
    .size   (req_size),
    .cmd    (cmd_v[ch_sel]),
    .sts    (sts_v[ch_sel]),
    .adr    (adr_v[ch_sel]),
    .rdata  (rd_fmt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rsp_rdata <= rd_fmt;
    end
  end
endmodule

// File: rtl/bmdma_regwin_chk.sv
module bmdma_regwin_chk #(
  parameter int NCH = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [$clog2(NCH)+2:0] req_addr,
  input logic [1:0]             req_size,
  input logic                   rsp_valid,
  input logic [NCH-1:0]         irq_in,
  input logic [NCH-1:0]         dma_start,
  input logic [NCH-1:0]         dma_to_mem,
  input logic [NCH-1:0]         irq_pending
);
  p_read_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_no_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(dma_start) && $stable(dma_to_mem)));

  p_wide_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_addr[2] && req_size != 2'd0)
      |=> ($stable(dma_start) && $stable(dma_to_mem)));

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_in[i] |=> irq_pending[i]);
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pending[i] && !(req_valid && req_write)) |=> irq_pending[i]);
  end
endmodule

bind bmdma_regwin bmdma_regwin_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .irq_in(irq_in), .dma_start(dma_start), .dma_to_mem(dma_to_mem),
  .irq_pending(irq_pending)
);

// File: tb/tb_bmdma_regwin.sv
`timescale 1ns/1ps
module tb_bmdma_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  irq_in = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  dma_start, dma_to_mem, irq_pending;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  bmdma_regwin #(.NCH(2)) dut (.*);

  // behavioural reference state
  bit          m_start[2], m_dir[2], m_act[2], m_irq[2], m_c5[2], m_c6[2];
  logic [31:0] m_adr[2];
  bit          e_rv;
  logic [31:0] e_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [3:0] a, logic [1:0] sz);
    int c = int'(a[3]);
    int ln = int'(a[1:0]);
    logic [31:0] full;
    if (!a[2]) begin
      if (sz == 2'd1) return 32'h0000FFFF;
      if (sz != 2'd0) return 32'hFFFFFFFF;
      if (ln == 0) return {28'b0, m_dir[c], 2'b00, m_start[c]};
      if (ln == 2) return {25'b0, m_c6[c], m_c5[c], 2'b00, m_irq[c], 1'b0, m_act[c]};
      return 32'h000000FF;
    end
    full = m_adr[c] & ~32'h3;
    if (sz >= 2'd2) return full;
    full = full >> (8 * ln);
    return (sz == 2'd0) ? (full & 32'hFF) : (full & 32'hFFFF);
  endfunction

  task automatic step(bit v, bit w, logic [3:0] a, logic [1:0] sz,
                      logic [31:0] wd, logic [1:0] irq, string tag);
    int c = int'(a[3]);
    int ln = int'(a[1:0]);
    req_valid = v; req_write = w; req_addr = a; req_size = sz;
    req_wdata = wd; irq_in = irq;
    e_rv = v && !w;
    if (e_rv) e_rd = mread(a, sz);
    if (v && w) begin
      if (!a[2]) begin
        if (sz == 2'd0 && ln == 0) begin
          m_start[c] = wd[0]; m_dir[c] = wd[3]; m_act[c] = wd[0];
        end else if (sz == 2'd0 && ln == 2) begin
          if (wd[2]) m_irq[c] = 0;
          m_c5[c] = wd[5]; m_c6[c] = wd[6];
        end
      end else begin
        for (int k = 0; k < 4; k++) begin
          bit cov;
          logic [31:0] b;
          if (sz >= 2'd2) begin cov = 1; b = wd >> (8 * k); end
          else begin
            cov = (k == ln) || (sz == 2'd1 && k == ln + 1);
            b = wd >> (8 * (k - ln));
          end
          if (cov) m_adr[c][8*k +: 8] = b[7:0];
        end
      end
    end
    for (int i = 0; i < 2; i++) if (irq[i]) m_irq[i] = 1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R1 rsp_valid"}, {31'b0, rsp_valid}, {31'b0, e_rv});
    chk({tag, " R1 req_ready"}, {31'b0, req_ready}, 32'd1);
    if (e_rv) chk({tag, " rdata"}, rsp_rdata, e_rd);
    chk({tag, " R3 dma_start"}, {30'b0, dma_start}, {30'b0, m_start[1], m_start[0]});
    chk({tag, " R3 dma_to_mem"}, {30'b0, dma_to_mem}, {30'b0, m_dir[1], m_dir[0]});
    chk({tag, " R5 irq_pending"}, {30'b0, irq_pending}, {30'b0, m_irq[1], m_irq[0]});
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] d, string tag);
    step(1, 1, a, sz, d, 2'b00, tag);
  endtask
  task automatic rd(logic [3:0] a, logic [1:0] sz, string tag);
    step(1, 0, a, sz, 32'h0, 2'b00, tag);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_start[i] = 0; m_dir[i] = 0; m_act[i] = 0; m_irq[i] = 0;
      m_c5[i] = 0; m_c6[i] = 0; m_adr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 reset outputs", {26'b0, rsp_valid, dma_start, dma_to_mem, irq_pending}, 32'h0);
    for (int c = 0; c < 2; c++) begin
      rd(4'(c*8 + 0), 2'd0, "R10 cmd");
      rd(4'(c*8 + 2), 2'd0, "R10 sts");
      rd(4'(c*8 + 4), 2'd2, "R10 adr");
    end
    // R3 R4 command and active
    wr(4'h0, 2'd0, 32'hFF, "R3 cmd all ones ch0");
    rd(4'h0, 2'd0, "R3 cmd readback");
    rd(4'h2, 2'd0, "R4 active set");
    wr(4'h2, 2'd0, 32'h01, "R4 active read-only");
    rd(4'h2, 2'd0, "R4 active still set");
    wr(4'h0, 2'd0, 32'h08, "R4 stop keeps dir");
    rd(4'h2, 2'd0, "R4 active cleared");
    wr(4'h8, 2'd0, 32'h01, "R3 ch1 start");
    // R5 interrupt
    step(0, 0, 4'h0, 2'd0, 0, 2'b01, "R5 irq pulse ch0");
    step(0, 0, 4'h0, 2'd0, 0, 2'b00, "R5 irq sticky");
    wr(4'h2, 2'd0, 32'h00, "R5 write 0 keeps");
    wr(4'h2, 2'd0, 32'h04, "R5 w1c clears");
    step(0, 0, 4'h0, 2'd0, 0, 2'b10, "R5 irq ch1");
    step(1, 1, 4'hA, 2'd0, 32'h04, 2'b10, "R5 set wins over clear");
    rd(4'hA, 2'd0, "R5 ch1 status");
    // R6 capability bits
    wr(4'h2, 2'd0, 32'hFF, "R6 write all ones");
    rd(4'h2, 2'd0, "R6 status mask");
    wr(4'h2, 2'd0, 32'h20, "R6 bit5 only");
    rd(4'h2, 2'd0, "R6 readback");
    // R7 filler lanes
    rd(4'h1, 2'd0, "R7 lane1");
    rd(4'hB, 2'd0, "R7 lane3");
    wr(4'h1, 2'd0, 32'h09, "R7 lane1 write");
    wr(4'h3, 2'd0, 32'h04, "R7 lane3 write");
    rd(4'h0, 2'd0, "R7 cmd unchanged");
    // R8 wide access to cmd/status dword
    rd(4'h0, 2'd1, "R8 half read");
    rd(4'h8, 2'd2, "R8 word read");
    rd(4'h2, 2'd3, "R8 size3 read");
    wr(4'h0, 2'd2, 32'h0000_0009, "R8 word write dropped");
    wr(4'h8, 2'd1, 32'h0000_0000, "R8 half write dropped");
    rd(4'h0, 2'd0, "R8 cmd unchanged");
    // R9 address dword
    wr(4'h4, 2'd2, 32'hDEAD_BEEF, "R9 word write");
    rd(4'h4, 2'd2, "R9 low bits zero");
    for (int l = 0; l < 4; l++) rd(4'(4 + l), 2'd0, "R9 byte lanes");
    for (int l = 0; l < 4; l++) rd(4'(4 + l), 2'd1, "R9 half lanes");
    wr(4'hF, 2'd1, 32'h0000_A55A, "R9 half clipped at lane3");
    wr(4'hD, 2'd0, 32'h0000_0077, "R9 byte lane1");
    wr(4'hE, 2'd1, 32'h0000_1234, "R9 half lane2");
    rd(4'hC, 2'd2, "R9 ch1 word");
    rd(4'h4, 2'd3, "R9 ch0 untouched");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      step(r[0] | r[1], r[2], r[7:4], r[9:8], $urandom, {r[12] & r[13], r[14] & r[15]},
           "R2 mixed");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule